// File: doc/BRIEF.md
# Self-Calibration Sequencer with Clock Divider

This block paces a converter's self-calibration run. A one-cycle start request is accepted only while the block is idle and none of the four trim-memory operation enables is set. On acceptance the block captures a step period, a power-of-two fraction of the converter clock, from a 6-bit rate field. It then walks a parameterised number of calibration steps, one per divided tick.

Each step produces a strobe, the step index and a result word from a stub that stands in for the analog measurement. A request flag mirrors the start bit and stays high while the run is active. On the final step the block drops that flag by itself and reports the calibrated state on a 2-bit status output. The total run time is NUM_STEPS times the captured period, so it grows with the period and shrinks as the converter clock gets faster.

Top module: `sc_selfcal_seq`

## Requirements
- R1: A start request (`start_set_i` high at a clock edge while idle) is accepted only when `mem_en_i` is 4'b0000. If any of its bits is 1, `busy_o` and `start_bit_o` stay 0 and no strobe follows.
- R2: After an accepted start edge, `busy_o` and `start_bit_o` read 1 and `cal_state_o` reads 2'b00 (uncalibrated) in the following cycle.
- R3: The step period in clock cycles is 4096 >> c, where c is `rate_i` for values 0 to 7 and c = 7 for any larger value. This gives 4096 for code 0 and 32 for code 7 and above.
- R4: Counting the accepted start edge as edge 0, strobe k (k = 0 .. NUM_STEPS-1) is high during the cycle that follows edge k*P + P - 1, where P is the step period. `step_idx_o` equals k during that strobe, and exactly NUM_STEPS strobes occur.
- R5: `done_o` is high only together with the strobe of the last step. In the next cycle `busy_o` = 0, `start_bit_o` = 0 and `cal_state_o` = 2'b01 (self-calibrated).
- R6: While a run is active, changes on `rate_i` and `mem_en_i` and any `start_set_i` pulse have no effect on its timing. This includes a pulse in the cycle where `done_o` is high, which leaves the block idle afterwards.
- R7: During each strobe, `step_res_o` equals (5*k + 3) mod 2^RES_W, where k is the step index.
- R8: After reset, `busy_o`, `start_bit_o`, `step_stb_o` and `done_o` are 0 and `cal_state_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_set_i | input | 1 | Start request pulse |
| rate_i | input | 6 | Rate field; the code saturates at 7 |
| mem_en_i | input | 4 | Trim-memory operation enables; any set bit blocks a start |
| busy_o | output | 1 | Run in progress |
| start_bit_o | output | 1 | Start bit; cleared by hardware at the end of a run |
| step_stb_o | output | 1 | One-cycle strobe per divided tick |
| step_idx_o | output | IDX_W | Index of the current step |
| step_res_o | output | RES_W | Stub step result |
| done_o | output | 1 | Last-step strobe |
| cal_state_o | output | 2 | 00 uncalibrated, 01 self-calibrated |

## Verification
The end of a run and a new start request can fall in the same cycle. The final-step strobe completes the run on the same edge at which a start pulse would be captured. The bench raises `start_set_i`, with all memory enables clear, so that it is sampled on the edge where `done_o` is high. It then requires the block to come out idle, with the start bit clear and status 01, instead of beginning a second run. A start pulse in the middle of a run, together with changes on the rate field and the enables, is judged by checking that the strobe schedule still matches the period captured at the start.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    CAL_NONE = 2'b00,
    CAL_SELF = 2'b01
  } cal_state_e;

  localparam int unsigned RATE_MAX = 7;

  function automatic logic [2:0] sat_rate(input logic [5:0] code);
    return (code > 6'(RATE_MAX)) ? 3'(RATE_MAX) : code[2:0];
  endfunction
endpackage

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int unsigned DIV_MAX = 4096,
  localparam int unsigned CNT_W  = $clog2(DIV_MAX)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] shift_i,
  input  logic       run_i,
  output logic       tick_o
);
  logic [CNT_W:0]   ratio_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   last_cnt;

  assign last_cnt = ratio_q - 1'b1;
  assign tick_o   = run_i && ({1'b0, cnt_q} == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= (CNT_W+1)'(DIV_MAX);
      cnt_q   <= '0;
    end else if (load_i) begin
      ratio_q <= (CNT_W+1)'(DIV_MAX) >> shift_i;
      cnt_q   <= '0;
    end else if (run_i) begin
      cnt_q   <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_step_ctr.sv
module sc_step_ctr #(
  parameter int unsigned NUM_STEPS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(NUM_STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (adv_i)   idx_q <= last_o ? '0 : idx_q + 1'b1;
  end
endmodule

// File: rtl/sc_result_stub.sv
module sc_result_stub #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned RES_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [RES_W-1:0] res_o
);
  // stand-in for the analog measurement: 5*idx + 3
  localparam int unsigned W = (IDX_W > RES_W) ? IDX_W : RES_W;
  logic [W+2:0] prod;

  assign prod  = (W+3)'(idx_i) * (W+3)'(5) + (W+3)'(3);
  assign res_o = prod[RES_W-1:0];
endmodule

// File: rtl/sc_selfcal_seq.sv
module sc_selfcal_seq #(
  parameter int unsigned NUM_STEPS = 64,
  parameter int unsigned DIV_MAX   = 4096,
  parameter int unsigned RES_W     = 8,
  parameter int unsigned IDX_W     = $clog2(NUM_STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_set_i,
  input  logic [5:0]       rate_i,
  input  logic [3:0]       mem_en_i,
  output logic             busy_o,
  output logic             start_bit_o,
  output logic             step_stb_o,
  output logic [IDX_W-1:0] step_idx_o,
  output logic [RES_W-1:0] step_res_o,
  output logic             done_o,
  output logic [1:0]       cal_state_o
);
  import sc_pkg::*;

  logic       busy_q, start_q;
  cal_state_e state_q;
  logic       go, tick, last;

  assign go = start_set_i && !busy_q && (mem_en_i == 4'b0000);

  sc_clk_div #(.DIV_MAX(DIV_MAX)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (go),
    .shift_i (sat_rate(rate_i)),
    .run_i   (busy_q),
    .tick_o  (tick)
  );

  sc_step_ctr #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) i_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (go),
    .adv_i   (tick),
    .idx_o   (step_idx_o),
    .last_o  (last)
  );

  sc_result_stub #(.IDX_W(IDX_W), .RES_W(RES_W)) i_stub (
    .idx_i (step_idx_o),
    .res_o (step_res_o)
  );

  assign step_stb_o  = tick;
  assign done_o      = tick && last;
  assign busy_o      = busy_q;
  assign start_bit_o = start_q;
  assign cal_state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      state_q <= CAL_NONE;
    end else if (go) begin
      busy_q  <= 1'b1;
      start_q <= 1'b1;
      state_q <= CAL_NONE;
    end else if (done_o) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      state_q <= CAL_SELF;
    end
  end
endmodule

// File: rtl/sc_selfcal_chk.sv
module sc_selfcal_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_set_i,
  input logic [3:0]       mem_en_i,
  input logic             busy_o,
  input logic             start_bit_o,
  input logic             step_stb_o,
  input logic [IDX_W-1:0] step_idx_o,
  input logic             done_o,
  input logic [1:0]       cal_state_o
);
  p_start_blocked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_set_i && !busy_o && mem_en_i != 4'b0000) |=> (!busy_o && !start_bit_o));

  p_start_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_set_i && !busy_o && mem_en_i == 4'b0000) |=> (busy_o && start_bit_o && cal_state_o == 2'b00));

  p_idx_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !step_stb_o) |=> $stable(step_idx_o));

  p_done_with_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (step_stb_o && busy_o));

  p_done_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !start_bit_o && cal_state_o == 2'b01));

  p_busy_ignores_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!step_stb_o && !done_o));
endmodule

bind sc_selfcal_seq sc_selfcal_chk #(.IDX_W(IDX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_set_i (start_set_i),
  .mem_en_i    (mem_en_i),
  .busy_o      (busy_o),
  .start_bit_o (start_bit_o),
  .step_stb_o  (step_stb_o),
  .step_idx_o  (step_idx_o),
  .done_o      (done_o),
  .cal_state_o (cal_state_o)
);

// File: tb/test_sc_selfcal_seq.sv
module test_sc_selfcal_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_STEPS    = 4;
  localparam int IW         = 2;
  localparam int RW         = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_set_i = 1'b0;
  logic [5:0]    rate_i = '0;
  logic [3:0]    mem_en_i = '0;
  logic          busy_o, start_bit_o, step_stb_o, done_o;
  logic [IW-1:0] step_idx_o;
  logic [RW-1:0] step_res_o;
  logic [1:0]    cal_state_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_selfcal_seq #(.NUM_STEPS(N_STEPS), .DIV_MAX(4096), .RES_W(RW)) i_sc_selfcal_seq (
    .clk_i, .rst_ni, .start_set_i, .rate_i, .mem_en_i,
    .busy_o, .start_bit_o, .step_stb_o, .step_idx_o, .step_res_o, .done_o, .cal_state_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check(busy_o == 0 && start_bit_o == 0, "R8 busy/start", {busy_o, start_bit_o}, 0);
    check(step_stb_o == 0 && done_o == 0, "R8 strobe/done", {step_stb_o, done_o}, 0);
    check(cal_state_o == 2'b00, "R8 state", cal_state_o, 0);
  endtask

  task automatic t_blocked(input int bitpos);
    @(negedge clk_i);
    mem_en_i = 4'(1 << bitpos);
    start_set_i = 1'b1;
    @(negedge clk_i);
    start_set_i = 1'b0;
    check(busy_o == 0 && start_bit_o == 0, "R1 blocked start", {busy_o, start_bit_o}, 0);
    repeat (40) begin
      @(negedge clk_i);
      if (step_stb_o) begin
        check(0, "R1 strobe after blocked start", 1, 0);
        break;
      end
    end
    mem_en_i = 4'b0000;
  endtask

  // one run; disturb: mid-run rate/enable/start changes; collide: start in the done cycle
  task automatic t_run(input logic [5:0] code, input int ratio, input bit disturb,
                       input bit collide, input string tag);
    int bad_t = 0;
    int a_v = 0;
    int e_v = 0;
    string which = "";
    @(negedge clk_i);
    rate_i = code;
    mem_en_i = 4'b0000;
    start_set_i = 1'b1;
    @(posedge clk_i);
    for (int j = 0; j < N_STEPS * ratio; j++) begin
      int k;
      bit e_stb;
      @(negedge clk_i);
      start_set_i = 1'b0;
      k = j / ratio;
      e_stb = (j % ratio) == ratio - 1;
      if (j == 0) begin
        check(busy_o && start_bit_o, {"R2 busy after start ", tag}, {busy_o, start_bit_o}, 3);
        check(cal_state_o == 2'b00, {"R2 state cleared ", tag}, cal_state_o, 0);
      end
      if (bad_t == 0) begin
        if (step_stb_o != e_stb) begin
          bad_t = 1; which = "R4 strobe timing"; a_v = step_stb_o; e_v = e_stb;
        end else if (!busy_o) begin
          bad_t = 1; which = "R6 busy dropped"; a_v = 0; e_v = 1;
        end else if (done_o != (e_stb && k == N_STEPS - 1)) begin
          bad_t = 1; which = "R5 done timing"; a_v = done_o; e_v = !done_o;
        end else if (e_stb && step_idx_o != IW'(k)) begin
          bad_t = 1; which = "R4 step index"; a_v = step_idx_o; e_v = k;
        end else if (e_stb && step_res_o != RW'(5 * k + 3)) begin
          bad_t = 1; which = "R7 step result"; a_v = step_res_o; e_v = (5 * k + 3) % 256;
        end
      end
      if (disturb && j == 3) begin
        rate_i = (code == 6'd0) ? 6'd7 : 6'd0;
        mem_en_i = 4'hF;
        start_set_i = 1'b1;
      end
      if (disturb && j == 6) mem_en_i = 4'h0;
      if (collide && j == N_STEPS * ratio - 1) begin
        mem_en_i = 4'h0;
        start_set_i = 1'b1;
      end
    end
    @(negedge clk_i);
    start_set_i = 1'b0;
    check(bad_t == 0, {which, " R3 ", tag}, a_v, e_v);
    check(!busy_o && !start_bit_o, {"R5 idle at end ", tag}, {busy_o, start_bit_o}, 0);
    check(cal_state_o == 2'b01, {"R5 state self-cal ", tag}, cal_state_o, 1);
    if (collide) begin
      @(negedge clk_i);
      check(!busy_o && !step_stb_o, "R6 start in done cycle ignored", busy_o, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    for (int b = 0; b < 4; b++) t_blocked(b);
    t_run(6'd7, 32, 1'b0, 1'b0, "code7");
    t_run(6'd3, 512, 1'b0, 1'b0, "code3");
    t_run(6'd9, 32, 1'b0, 1'b0, "code9 saturates");
    t_run(6'd63, 32, 1'b1, 1'b0, "code63 disturbed");
    t_run(6'd0, 4096, 1'b0, 1'b0, "code0 default");
    t_run(6'd6, 64, 1'b1, 1'b1, "code6 collision");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule